// File: doc/BRIEF.md
# Serial Register Write Port

A write-only serial slave that turns a stream of bits on three wires into register write strobes inside the chip. A host raises chip select (active high), then clocks in a 16-bit frame, most significant bit first, with each bit sampled on the rising edge of the serial clock. The first bit on the wire is a command bit that must be 0 for a write. It is followed by a 7-bit register address and then 8 data bits.

The three serial pins are brought into the system clock domain through a short synchronizer chain, and all frame logic runs on the system clock. A complete write frame produces one system-clock pulse on the write strobe, with the address and data held on their outputs. The serial clock may run up to 13 MHz, which leaves about nine system cycles per serial period at 125 MHz. Frames that are short, that carry command bit 1, or that run past 16 bits do not cause extra writes.

Top module: `spiw_reg_port`

## Requirements
- R1: After reset, `wr_en` is 0 and `wr_addr` and `wr_data` are all zeros.
- R2: A frame whose first bit is 0 produces exactly one single-cycle `wr_en` pulse. On that pulse, `wr_addr` carries frame bits 14..8 and `wr_data` carries bits 7..0 (bit 15 is sent first).
- R3: A frame whose first bit is 1 produces no `wr_en` pulse.
- R4: If chip select falls after fewer than 16 accepted bits, the frame is discarded and no write occurs.
- R5: Rising serial clock edges after the 16th bit, while chip select stays high, are ignored. They cause no further pulse and no change of `wr_addr` or `wr_data`.
- R6: The bit counter returns to zero each time chip select rises, so a frame that follows a discarded one is decoded from its own first bit.
- R7: Serial clock edges while chip select is low are not counted.
- R8: A rising serial clock edge that reaches the synchronizer output in the same cycle as the falling chip select is not accepted.
- R9: `wr_en` rises SYNC_STAGES+1 system cycles (3 by default) after the system cycle in which the 16th rising serial clock edge is applied at the pin.
- R10: While `wr_en` is 0, `wr_addr` and `wr_data` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs | input | 1 | Chip select, active high |
| spi_sclk | input | 1 | Serial clock, bits taken on its rising edge |
| spi_mosi | input | 1 | Serial data in, MSB first |
| wr_en | output | 1 | Single-cycle register write strobe |
| wr_addr | output | 7 | Register address of the write |
| wr_data | output | 8 | Register data of the write |

## Verification
The closing serial clock edge of a frame and the release of chip select can reach the core logic in the same system cycle. The block must then treat the frame as short rather than complete. The bench provokes this by driving the 16th rising clock edge and the falling chip select in the same system cycle, so both pass through identical synchronizer stages together. It then judges the outcome by requiring an empty scoreboard and no strobe, while a clean frame sent right after must still decode correctly.

// File: rtl/spiw_pkg.sv
package spiw_pkg;
  parameter int ADDR_W     = 7;
  parameter int DATA_W     = 8;
  parameter int FRAME_BITS = 1 + ADDR_W + DATA_W;
  parameter int CNT_W      = $clog2(FRAME_BITS + 1);
  parameter logic CMD_WRITE = 1'b0;

  typedef struct packed {
    logic              cmd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;

  function automatic frame_t unpack_frame(input logic [FRAME_BITS-1:0] word);
    frame_t f;
    f.cmd  = word[FRAME_BITS-1];
    f.addr = word[FRAME_BITS-2 -: ADDR_W];
    f.data = word[DATA_W-1:0];
    return f;
  endfunction

  function automatic logic wants_write(input frame_t f);
    return f.cmd == CMD_WRITE;
  endfunction

  function automatic logic is_last_bit(input logic [CNT_W-1:0] cnt);
    return cnt == CNT_W'(FRAME_BITS - 1);
  endfunction
endpackage

// File: rtl/spiw_sync.sv
module spiw_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/spiw_shifter.sv
module spiw_shifter
  import spiw_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_s,
  input  logic                  sclk_s,
  input  logic                  mosi_s,
  output logic                  bit_accept,
  output logic                  frame_done,
  output logic [FRAME_BITS-1:0] frame_word,
  output logic [CNT_W-1:0]      bit_cnt
);
  logic                  sclk_d;
  logic                  cs_d;
  logic [FRAME_BITS-2:0] shreg;
  logic                  sclk_rise;
  logic                  cs_rise;
  logic                  cnt_full;

  assign sclk_rise  = sclk_s & ~sclk_d;
  assign cs_rise    = cs_s & ~cs_d;
  assign cnt_full   = (bit_cnt == CNT_W'(FRAME_BITS));
  assign bit_accept = sclk_rise & cs_s & ~cs_rise & ~cnt_full;
  assign frame_word = {shreg, mosi_s};
  assign frame_done = bit_accept & is_last_bit(bit_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      cs_d    <= 1'b0;
      shreg   <= '0;
      bit_cnt <= '0;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
      if (cs_rise) begin
        bit_cnt <= '0;
      end else if (bit_accept) begin
        bit_cnt <= bit_cnt + 1'b1;
        shreg   <= frame_word[FRAME_BITS-2:0];
      end
    end
  end
endmodule

// File: rtl/spiw_write_issue.sv
module spiw_write_issue
  import spiw_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_done,
  input  logic [FRAME_BITS-1:0] frame_word,
  output logic                  wr_en,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [DATA_W-1:0]     wr_data
);
  frame_t fr;
  logic   do_write;

  assign fr       = unpack_frame(frame_word);
  assign do_write = frame_done & wants_write(fr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= do_write;
      if (do_write) begin
        wr_addr <= fr.addr;
        wr_data <= fr.data;
      end
    end
  end
endmodule

// File: rtl/spiw_reg_port.sv
module spiw_reg_port
  import spiw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int PINS = 3;

  logic [PINS-1:0]       pins_s;
  logic                  cs_sync;
  logic                  sclk_sync;
  logic                  mosi_sync;
  logic                  bit_accept;
  logic                  frame_done;
  logic [FRAME_BITS-1:0] frame_word;
  logic [CNT_W-1:0]      bit_cnt;

  spiw_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({spi_cs, spi_sclk, spi_mosi}),
    .q_sync  (pins_s)
  );

  assign {cs_sync, sclk_sync, mosi_sync} = pins_s;

  spiw_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_s       (cs_sync),
    .sclk_s     (sclk_sync),
    .mosi_s     (mosi_sync),
    .bit_accept (bit_accept),
    .frame_done (frame_done),
    .frame_word (frame_word),
    .bit_cnt    (bit_cnt)
  );

  spiw_write_issue u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .frame_word (frame_word),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data)
  );
endmodule

// File: rtl/spiw_checker.sv
module spiw_checker
  import spiw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic              bit_accept,
  input logic              frame_done,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  assert_strobe_needs_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(frame_done));

  assert_full_count_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bit_cnt) == CNT_W'(FRAME_BITS)) |-> !wr_en);

  assert_count_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_s) |=> (bit_cnt == '0));

  assert_idle_no_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> $stable(bit_cnt));

  assert_no_write_after_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_s) |=> !wr_en);

  assert_fields_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> ($stable(wr_addr) && $stable(wr_data)));

  assert_accept_counts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_accept && !frame_done) |=> (bit_cnt == $past(bit_cnt) + 1'b1));
endmodule

bind spiw_reg_port spiw_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_s       (cs_sync),
  .bit_accept (bit_accept),
  .frame_done (frame_done),
  .bit_cnt    (bit_cnt),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data)
);

// File: tb/tb_spiw_reg_port.sv
module tb_spiw_reg_port;
  localparam int HALF    = 6;
  localparam int LATENCY = 3;
  localparam int WDOG    = 100000;

  typedef struct {
    logic [6:0] addr;
    logic [7:0] data;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_cs = 1'b0;
  logic spi_sclk = 1'b0;
  logic spi_mosi = 1'b0;
  logic wr_en;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int last_rise = 0;
  bit prev_en = 1'b0;
  bit finished = 1'b0;
  item_t exp_q[$];
  logic [6:0] last_addr = '0;
  logic [7:0] last_data = '0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spiw_reg_port dut (
    .clk(clk), .rst_n(rst_n), .spi_cs(spi_cs), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // monitor: pops expected writes as strobes appear
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (wr_en && prev_en) begin
        checks++; fails++;
        $display("FAIL R2: strobe wider than one cycle, actual 2+ cycles expected 1");
      end
      if (wr_en && !prev_en) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R3/R4/R5/R7/R8: unexpected write actual %h/%h expected none",
                   wr_addr, wr_data);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          if (wr_addr !== e.addr || wr_data !== e.data) begin
            fails++;
            $display("FAIL R2 (%s): actual %h/%h expected %h/%h",
                     e.tag, wr_addr, wr_data, e.addr, e.data);
          end
          checks++;
          if (cyc - last_rise != LATENCY) begin
            fails++;
            $display("FAIL R9 (%s): latency actual %0d expected %0d",
                     e.tag, cyc - last_rise, LATENCY);
          end
        end
      end
      prev_en <= wr_en;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_up();
    @(negedge clk); spi_cs = 1'b1; wait_n(HALF);
  endtask

  task automatic cs_down();
    wait_n(HALF); spi_cs = 1'b0; wait_n(4);
  endtask

  task automatic clock_bits(input logic [31:0] word, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = word[nbits-1-i];
      wait_n(HALF);
      spi_sclk = 1'b1; last_rise = cyc;
      wait_n(HALF);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic expect_write(input logic [6:0] a, input logic [7:0] d, input string tag);
    item_t e;
    e.addr = a; e.data = d; e.tag = tag;
    exp_q.push_back(e);
    last_addr = a; last_data = d;
  endtask

  task automatic send_frame(input logic cmd, input logic [6:0] a, input logic [7:0] d,
                            input string tag);
    if (cmd == 1'b0) expect_write(a, d, tag);
    cs_up();
    clock_bits({16'h0, cmd, a, d}, 16);
    cs_down();
  endtask

  task automatic drained(input string tag);
    wait_n(10);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s: pending writes actual %0d expected 0", tag, exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic fields_held(input string tag);
    checks++;
    if (wr_addr !== last_addr || wr_data !== last_data) begin
      fails++;
      $display("FAIL %s: held fields actual %h/%h expected %h/%h",
               tag, wr_addr, wr_data, last_addr, last_data);
    end
  endtask

  initial begin
    wait_n(5);
    // R1: reset values
    checks++;
    if (wr_en !== 1'b0 || wr_addr !== 7'h00 || wr_data !== 8'h00) begin
      fails++;
      $display("FAIL R1: reset actual %b/%h/%h expected 0/00/00", wr_en, wr_addr, wr_data);
    end
    rst_n = 1'b1;
    wait_n(5);

    // R2, R9: plain writes with varied patterns
    send_frame(1'b0, 7'h15, 8'hA5, "R2 a");
    send_frame(1'b0, 7'h7F, 8'hFF, "R2 ones");
    send_frame(1'b0, 7'h00, 8'h00, "R2 zeros");
    send_frame(1'b0, 7'h40, 8'h01, "R2 edges");
    drained("R2");

    // R3: command bit 1 ignored
    send_frame(1'b1, 7'h2A, 8'h3C, "R3");
    drained("R3");
    fields_held("R3");

    // R4: short frame discarded, R6: next frame decodes from its own first bit
    cs_up(); clock_bits(32'h0000_1FF, 9); cs_down();
    drained("R4");
    fields_held("R4");
    send_frame(1'b0, 7'h33, 8'h5A, "R6");
    drained("R6");

    // R5: extra bits after the 16th while select stays high
    expect_write(7'h0C, 8'hC3, "R5");
    cs_up(); clock_bits({8'h0, 1'b0, 7'h0C, 8'hC3, 8'hFF}, 24); cs_down();
    drained("R5");
    fields_held("R5");

    // R7: clock activity with select low
    clock_bits(32'hFFFF_FFFF, 20);
    drained("R7");
    fields_held("R7");
    send_frame(1'b0, 7'h61, 8'h96, "R7 after");
    drained("R7 after");

    // R8: last edge coincides with select release
    cs_up();
    clock_bits({17'h0, 1'b0, 7'h11, 7'h3B}, 15);
    spi_mosi = 1'b1;
    wait_n(HALF);
    spi_sclk = 1'b1; spi_cs = 1'b0;
    wait_n(HALF);
    spi_sclk = 1'b0;
    drained("R8");
    fields_held("R8");
    send_frame(1'b0, 7'h2E, 8'h71, "R8 after");
    drained("R8 after");

    // R10: fields stay put during idle time
    wait_n(20);
    fields_held("R10");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait_n(WDOG);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule